// File: doc/BRIEF.md
# UART Receive Buffer and Status Registers

This block is the receive half of a memory-mapped serial port. A deserializer hands it one byte at a time, together with per-byte parity and framing error flags and a separate line-break indication. The bytes are kept in a circular queue whose depth is a parameter, 16 by default. Software reads them, and the state around them, through a small register port: one word per address, a single valid strobe with a write flag, and read data returned on the clock edge after the request.

A control bit selects FIFO mode. With the bit clear, the block keeps only the most recent byte in a single holding register. Two self-clearing control bits discard the receive queue, or ask the transmit side to discard its own queue. The block raises two one-cycle event pulses for a separate interrupt controller: one for every byte that arrives, and one for every receive error. A receive error is a byte dropped on a full queue, or a read from an empty queue.

The register addresses are word indices on `bus_addr`: 0 control, 1 transfer status, 2 error status, 3 queue status, 4 receive data.

Top module: `rxq_status_top`

## Requirements
- R1: After reset, a read of control (address 0) returns 0, which means FIFO mode is off. Transfer status (address 1) returns 0x6, error status (address 2) returns 0, queue status (address 3) returns 0, and `tx_flush` is low. Read data appears on `bus_rdata` one cycle after the read request.
- R2: Queue status holds the number of stored bytes in bits [7:0] and a full flag in bit 8. The queue holds DEPTH bytes. When the queue is full the read value is exactly 0x100, so the count field shows zero.
- R3: In FIFO mode, each read of receive data (address 4) returns the oldest stored byte and removes it. Transfer status bit 0 (data ready) is 1 exactly while bytes remain in the queue. Bits 2:1 of transfer status always read 1.
- R4: A control write stores bit 0 as the FIFO-mode enable. Bit 1 empties the receive queue, and a byte arriving in that same cycle is discarded. Bit 2 drives `tx_flush` high for the one cycle after the write. Bits 1 and 2 always read back 0.
- R5: With FIFO mode off, an arriving byte overwrites the holding register and sets data ready. A read of receive data returns the holding register and clears data ready.
- R6: In FIFO mode, a read of receive data from an empty queue returns 0, and `ev_err` is high in the following cycle. The exception is the case R11 describes.
- R7: In FIFO mode, a byte that finds the queue full, with no removal in the same cycle, is dropped. `ev_err` pulses, error-status bit 0 (overrun) is set, and the stored bytes are unchanged.
- R8: An arriving byte flagged with a parity error sets error-status bit 1. One flagged with a framing error sets bit 2. A read of error status returns its value and clears it, but a bit set in the same cycle as the read survives into the next value.
- R9: A break indication stores a 0x00 byte (into the queue in FIFO mode) and sets error-status bit 3.
- R10: Every arriving byte or break, dropped or not, drives `ev_rx` high for the following cycle.
- R11: A byte arriving in the same cycle as a read of receive data in FIFO mode leaves the count unchanged and raises no error. On a non-empty queue the read returns the head byte and the new byte is appended. On an empty queue the read returns the arriving byte.
- R12: Writes to addresses 1 to 4 are ignored. They change no register, no queued byte and no event output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A received byte is present this cycle |
| in_byte | input | 8 | Received byte |
| in_parity_err | input | 1 | Parity error flag for the byte on `in_byte` |
| in_frame_err | input | 1 | Framing error flag for the byte on `in_byte` |
| in_break | input | 1 | Line break detected this cycle |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| ev_rx | output | 1 | Byte-arrival event pulse |
| ev_err | output | 1 | Receive error event pulse (overflow or underflow) |
| tx_flush | output | 1 | Request to empty the transmit queue |

## Verification
The checker assumes that `in_valid` and `in_break` are never high together, and that the port carries at most one access per cycle. A break takes priority in the logic, but the checker's implications are only meaningful for one source at a time. The bench raises a break alone, with `in_valid` low, and issues every register access from a single task, so two accesses never overlap. Same-cycle arrival and read is driven on purpose, and only in the R8 and R11 scenarios. Elsewhere the bench keeps arrivals and reads in separate cycles, so that underflow and overflow appear in their pure forms.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic [2:0] {
        REG_CTRL   = 3'd0,
        REG_XFER   = 3'd1,
        REG_ERRS   = 3'd2,
        REG_FSTAT  = 3'd3,
        REG_RXDATA = 3'd4
    } reg_sel_e;

    // Control bit positions
    localparam int CTL_EN    = 0;
    localparam int CTL_RXCLR = 1;
    localparam int CTL_TXCLR = 2;

    // Error status layout, MSB first: break, frame, parity, overrun
    typedef struct packed {
        logic brk;
        logic frame;
        logic parity;
        logic ovr;
    } err_flags_t;

    // Queue status word: count field zeroed when the full flag is set
    function automatic logic [31:0] pack_fstat(input logic [7:0] cnt, input logic full);
        return {23'd0, full, (full ? 8'd0 : cnt)};
    endfunction

endpackage

// File: rtl/rxq_ring.sv
module rxq_ring #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  head,
    output logic [CW-1:0] occ,
    output logic          full,
    output logic          empty
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wp] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= bump(wp);
            if (pop)  rp <= bump(rp);
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end

    assign head  = mem[rp];
    assign occ   = cnt;
    assign full  = (cnt == CW'(DEPTH));
    assign empty = (cnt == '0);

endmodule

// File: rtl/rxq_errlog.sv
module rxq_errlog
    import rxq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  err_flags_t set_f,
    input  logic       rd_clr,
    output err_flags_t val
);

    always_ff @(posedge clk) begin
        if (rst) begin
            val <= '0;
        end else begin
            val <= (rd_clr ? err_flags_t'('0) : val) | set_f;
        end
    end

endmodule

// File: rtl/rxq_status_top.sv
module rxq_status_top
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,       // 2 .. 255 so the count fits its 8-bit field
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [7:0]  in_byte,
    input  logic        in_parity_err,
    input  logic        in_frame_err,
    input  logic        in_break,
    input  logic        bus_valid,
    input  logic        bus_write,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        ev_rx,
    output logic        ev_err,
    output logic        tx_flush
);

    logic          fifo_en;
    logic [7:0]    hold_q;
    logic          hold_v;
    logic [7:0]    head;
    logic [CW-1:0] occ;
    logic          full, empty;
    err_flags_t    err_q, err_set;
    logic          unused_wdata;

    reg_sel_e sel;
    logic wr, rd, wr_ctrl, rd_rx, rd_err, rx_clr;
    logic arrive, want_pop, bypass, pop_ok, push_ok, underflow, dropped, rdy;
    logic [7:0] arrive_byte;
    logic [31:0] rd_mux;

    assign unused_wdata = ^bus_wdata[31:3];

    assign sel      = reg_sel_e'(bus_addr);
    assign wr       = bus_valid &  bus_write;
    assign rd       = bus_valid & ~bus_write;
    assign wr_ctrl  = wr && (sel == REG_CTRL);
    assign rd_rx    = rd && (sel == REG_RXDATA);
    assign rd_err   = rd && (sel == REG_ERRS);
    assign rx_clr   = wr_ctrl & bus_wdata[CTL_RXCLR];

    assign arrive      = in_valid | in_break;
    assign arrive_byte = in_break ? 8'h00 : in_byte;

    // Queue admission and removal
    assign want_pop  = fifo_en & rd_rx;
    assign bypass    = want_pop & empty & arrive;
    assign pop_ok    = want_pop & ~empty;
    assign underflow = want_pop & empty & ~arrive;
    assign push_ok   = fifo_en & arrive & ~rx_clr & ~bypass & (~full | pop_ok);
    assign dropped   = fifo_en & arrive & ~rx_clr & full & ~pop_ok;

    rxq_ring #(.DEPTH(DEPTH), .W(8)) ring_i (
        .clk   (clk),
        .rst   (rst),
        .clr   (rx_clr),
        .push  (push_ok),
        .pop   (pop_ok),
        .din   (arrive_byte),
        .head  (head),
        .occ   (occ),
        .full  (full),
        .empty (empty)
    );

    always_comb begin
        err_set        = '0;
        err_set.ovr    = dropped;
        err_set.parity = in_valid & in_parity_err;
        err_set.frame  = in_valid & in_frame_err;
        err_set.brk    = in_break;
    end

    rxq_errlog errlog_i (
        .clk    (clk),
        .rst    (rst),
        .set_f  (err_set),
        .rd_clr (rd_err),
        .val    (err_q)
    );

    // Control, holding register and event pulses
    always_ff @(posedge clk) begin
        if (rst) begin
            fifo_en  <= 1'b0;
            hold_q   <= '0;
            hold_v   <= 1'b0;
            ev_rx    <= 1'b0;
            ev_err   <= 1'b0;
            tx_flush <= 1'b0;
        end else begin
            if (wr_ctrl) fifo_en <= bus_wdata[CTL_EN];
            if (!fifo_en && arrive) begin
                hold_q <= arrive_byte;
                hold_v <= 1'b1;
            end else if (!fifo_en && rd_rx) begin
                hold_v <= 1'b0;
            end
            ev_rx    <= arrive;
            ev_err   <= dropped | underflow;
            tx_flush <= wr_ctrl & bus_wdata[CTL_TXCLR];
        end
    end

    assign rdy = fifo_en ? ~empty : hold_v;

    always_comb begin
        case (sel)
            REG_CTRL:   rd_mux = {31'd0, fifo_en};
            REG_XFER:   rd_mux = {29'd0, 2'b11, rdy};
            REG_ERRS:   rd_mux = {28'd0, err_q};
            REG_FSTAT:  rd_mux = pack_fstat(8'(occ), full);
            REG_RXDATA: begin
                if (!fifo_en)    rd_mux = {24'd0, hold_q};
                else if (bypass) rd_mux = {24'd0, arrive_byte};
                else if (empty)  rd_mux = 32'd0;
                else             rd_mux = {24'd0, head};
            end
            default:    rd_mux = 32'd0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (rd) begin
            bus_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/rxq_status_chk.sv
module rxq_status_chk #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          in_break,
    input logic          bus_valid,
    input logic          bus_write,
    input logic [2:0]    bus_addr,
    input logic [31:0]   bus_wdata,
    input logic [31:0]   bus_rdata,
    input logic          ev_rx,
    input logic          ev_err,
    input logic [CW-1:0] occ,
    input logic          fifo_en
);

    logic rd_rx_c, wr_clr_c, rd_fst_c;
    assign rd_rx_c  = bus_valid && !bus_write && (bus_addr == 3'd4);
    assign rd_fst_c = bus_valid && !bus_write && (bus_addr == 3'd3);
    assign wr_clr_c = bus_valid &&  bus_write && (bus_addr == 3'd0) && bus_wdata[1];

    // R6
    underflow_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_rx_c && fifo_en && occ == '0 && !in_valid && !in_break) |=> (ev_err && bus_rdata == 32'd0));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && fifo_en && occ == CW'(DEPTH) && !rd_rx_c && !wr_clr_c) |=> (ev_err && occ == CW'(DEPTH)));

    // R11
    pushpop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_break && rd_rx_c && fifo_en && occ != '0) |=> ($stable(occ) && !ev_err));

    // R4
    rx_clear_chk: assert property (@(posedge clk) disable iff (rst)
        wr_clr_c |=> (occ == '0));

    // R10
    rx_event_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid || in_break) |=> ev_rx);

    // R2
    full_word_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_fst_c && occ == CW'(DEPTH)) |=> (bus_rdata == 32'h100));

endmodule

bind rxq_status_top rxq_status_chk #(.DEPTH(DEPTH)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_break  (in_break),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ev_rx     (ev_rx),
    .ev_err    (ev_err),
    .occ       (occ),
    .fifo_en   (fifo_en)
);

// File: tb/rxq_status_top_tb_top.sv
`timescale 1ns/1ps
module rxq_status_top_tb_top;

    localparam int D = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0, in_parity_err = 1'b0, in_frame_err = 1'b0, in_break = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ev_rx, ev_err, tx_flush;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    rxq_status_top #(.DEPTH(D)) dut_i (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_byte(in_byte),
        .in_parity_err(in_parity_err), .in_frame_err(in_frame_err), .in_break(in_break),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_rx(ev_rx), .ev_err(ev_err), .tx_flush(tx_flush)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        step();
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = v;
        step();
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rx(input logic [7:0] b, input logic p, input logic f);
        in_valid = 1'b1; in_byte = b; in_parity_err = p; in_frame_err = f;
        step();
        in_valid = 1'b0; in_parity_err = 1'b0; in_frame_err = 1'b0;
        chk("R10 ev_rx", {31'd0, ev_rx}, 32'd1);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [7:0]  q[$];
        repeat (3) step();
        rst = 1'b0;

        // R1 reset state
        rd(3'd0, d); chk("R1 ctrl", d, 32'h0);
        rd(3'd1, d); chk("R1 xfer", d, 32'h6);
        rd(3'd2, d); chk("R1 err", d, 32'h0);
        rd(3'd3, d); chk("R1 fstat", d, 32'h0);
        chk("R1 tx_flush", {31'd0, tx_flush}, 32'd0);

        // R5 holding register mode
        rx(8'h5A, 1'b0, 1'b0);
        rd(3'd1, d); chk("R5 ready set", d, 32'h7);
        rd(3'd4, d); chk("R5 hold data", d, 32'h5A);
        rd(3'd1, d); chk("R5 ready clear", d, 32'h6);
        rx(8'h11, 1'b0, 1'b0);
        rx(8'h22, 1'b0, 1'b0);
        rd(3'd4, d); chk("R5 overwrite", d, 32'h22);

        // R4 enable FIFO mode
        wr(3'd0, 32'h1);
        rd(3'd0, d); chk("R4 ctrl en", d, 32'h1);

        // Sweep fill levels: R2, R3, R6, R7
        for (int n = 0; n <= D + 2; n++) begin
            int m;
            wr(3'd0, 32'h3);
            rd(3'd3, d); chk("R4 cleared", d, 32'h0);
            q.delete();
            for (int i = 0; i < n; i++) begin
                logic [7:0] b;
                b = 8'((n * 13 + i * 7 + 1) & 8'hFF);
                rx(b, 1'b0, 1'b0);
                chk("R7 ev_err on push", {31'd0, ev_err}, (i >= D) ? 32'd1 : 32'd0);
                if (i < D) q.push_back(b);
            end
            rd(3'd3, d); chk("R2 fstat", d, (n >= D) ? 32'h100 : 32'(n));
            rd(3'd2, d); chk("R7 overrun bit", d, (n > D) ? 32'h1 : 32'h0);
            m = q.size();
            for (int k = 0; k < m; k++) begin
                rd(3'd4, d); chk("R3 order", d, {24'd0, q[k]});
                chk("R3 no err", {31'd0, ev_err}, 32'd0);
                rd(3'd1, d); chk("R3 ready", d, (k < m - 1) ? 32'h7 : 32'h6);
            end
            rd(3'd4, d); chk("R6 empty data", d, 32'h0);
            chk("R6 ev_err", {31'd0, ev_err}, 32'd1);
        end

        // R8 error flags and clear-on-read
        wr(3'd0, 32'h3);
        rx(8'h31, 1'b1, 1'b0);
        rx(8'h32, 1'b0, 1'b1);
        rd(3'd2, d); chk("R8 parity+frame", d, 32'h6);
        rd(3'd2, d); chk("R8 cleared", d, 32'h0);
        in_valid = 1'b1; in_byte = 8'h33; in_parity_err = 1'b1;
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 3'd2;
        step();
        in_valid = 1'b0; in_parity_err = 1'b0; bus_valid = 1'b0;
        chk("R8 read old", bus_rdata, 32'h0);
        rd(3'd2, d); chk("R8 same-cycle set kept", d, 32'h2);

        // R9 break
        wr(3'd0, 32'h3);
        in_break = 1'b1; step(); in_break = 1'b0;
        chk("R10 ev_rx break", {31'd0, ev_rx}, 32'd1);
        rd(3'd2, d); chk("R9 break bit", d, 32'h8);
        rd(3'd3, d); chk("R9 count", d, 32'h1);
        rd(3'd4, d); chk("R9 null byte", d, 32'h0);
        chk("R9 no err", {31'd0, ev_err}, 32'd0);

        // R11 simultaneous push and pop on a full queue
        wr(3'd0, 32'h3);
        for (int i = 0; i < D; i++) rx(8'(8'h40 + i), 1'b0, 1'b0);
        in_valid = 1'b1; in_byte = 8'hEE;
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 3'd4;
        step();
        in_valid = 1'b0; bus_valid = 1'b0;
        chk("R11 head", bus_rdata, 32'h40);
        chk("R11 no err", {31'd0, ev_err}, 32'd0);
        rd(3'd3, d); chk("R11 still full", d, 32'h100);
        for (int i = 1; i < D; i++) begin
            rd(3'd4, d); chk("R11 drain", d, 32'(8'h40 + i));
        end
        rd(3'd4, d); chk("R11 appended", d, 32'hEE);
        // R11 on empty queue
        in_valid = 1'b1; in_byte = 8'h77;
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 3'd4;
        step();
        in_valid = 1'b0; bus_valid = 1'b0;
        chk("R11 bypass data", bus_rdata, 32'h77);
        chk("R11 bypass no err", {31'd0, ev_err}, 32'd0);
        rd(3'd3, d); chk("R11 bypass count", d, 32'h0);

        // R4 transmit flush and clear with concurrent arrival
        rx(8'hA1, 1'b0, 1'b0); rx(8'hA2, 1'b0, 1'b0); rx(8'hA3, 1'b0, 1'b0);
        wr(3'd0, 32'h5);
        chk("R4 tx_flush", {31'd0, tx_flush}, 32'd1);
        step();
        chk("R4 tx_flush one cycle", {31'd0, tx_flush}, 32'd0);
        rd(3'd0, d); chk("R4 ctrl readback", d, 32'h1);
        rd(3'd3, d); chk("R4 rx kept", d, 32'h3);
        in_valid = 1'b1; in_byte = 8'hB0;
        wr(3'd0, 32'h3);
        in_valid = 1'b0;
        rd(3'd3, d); chk("R4 clear drops arrival", d, 32'h0);

        // R12 writes to read-only addresses
        rx(8'hC1, 1'b1, 1'b0);
        rx(8'hC2, 1'b0, 1'b0);
        for (int a = 1; a <= 4; a++) begin
            wr(3'(a), 32'hFFFF_FFFF);
            chk("R12 no event", {30'd0, ev_err, tx_flush}, 32'd0);
        end
        rd(3'd3, d); chk("R12 count", d, 32'h2);
        rd(3'd2, d); chk("R12 err", d, 32'h2);
        rd(3'd1, d); chk("R12 xfer", d, 32'h7);
        rd(3'd0, d); chk("R12 ctrl", d, 32'h1);
        rd(3'd4, d); chk("R12 data", d, 32'hC1);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule